// File: doc/BRIEF.md
# Machine-mode CSR file

This block is the control and status register file of a 32-bit core that runs only in machine mode. The pipeline presents one access per cycle: a 12-bit register address, an operation (read, write, set bits, clear bits), the value of the source register or immediate, and the 5-bit source field. The block returns the current value of the selected register in the same cycle. The write lands at the next rising clock edge. An access to an address that does not exist, or a write attempt to an identification register, raises an illegal-instruction flag in the same cycle, and no state changes.

The pipeline also sends two strobes. A trap-entry strobe saves the exception PC and cause and pushes the interrupt-enable bit onto its one-deep stack. A trap-return strobe pops that stack. The block holds a free-running 64-bit cycle counter that software reads and writes as two 32-bit halves. It also holds constant identification words: the ISA word reflects whether the multiply/divide extension is built in, and the implementation word packs the core version as a major and a minor 16-bit half.

Top module: `mcsr_file`

## Requirements
- R1: Addresses 0x311, 0x312 and 0x314 read as zero. Address 0x313 reads {major[15:0], minor[15:0]}, which is 0x00010014 for the default version 1.20.
- R2: Address 0x301 reads 0x40001100 (bit 30, bit 12, bit 8) when the multiply extension is enabled, and 0x40000100 when it is disabled.
- R3: The operation encoding is 00 = read only, 01 = write the operand, 10 = OR in the operand, 11 = AND with the inverted operand. The read data is always the value from before the access, and the new value is visible in the next cycle.
- R4: Set (10) and clear (11) with a zero source field perform no write and never raise the illegal flag, even on a read-only address.
- R5: A valid access to any unlisted address raises the illegal flag. A write attempt to 0x311 to 0x314 also raises it. An illegal access changes no state.
- R6: Address 0x300 holds the global interrupt enable in bit 3 and the saved enable in bit 7. Bits 12:11 always read 11 and all other bits read 0. Bit 3 drives irq_global_en_o.
- R7: Trap vector (0x305) and exception PC (0x341) force bits 1:0 to zero. Interrupt enable (0x304) keeps only bits 3, 7, 11 and 31:16. The custom register 0x7C0 keeps only bit 0, which drives single_step_o. Scratch (0x340) and cause (0x342) keep all 32 bits.
- R8: Writes to 0x301 and to the pending register 0x344 are legal and are ignored. 0x344 reads irq_pending_i masked to bits 3, 7, 11 and 31:16.
- R9: The 64-bit counter advances by one every cycle. 0xB00 reads its low half and 0xB80 its high half, and a carry passes from the low half into the high half. A write loads only the addressed half, and the counter resumes counting from the loaded value one cycle later.
- R10: On trap entry the saved enable takes the enable, the enable clears, the exception PC loads trap_pc_i with bits 1:0 cleared, and the cause loads trap_cause_i. Trap entry wins over trap return, and a software write in the same cycle is dropped.
- R11: On trap return (without trap entry) the enable takes the saved enable, and the saved enable is set to 1.
- R12: After reset, the status word reads 0x00001800, the trap vector holds TVEC_RESET, and every other writable register and the counter hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_op_i | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| acc_addr_i | input | 12 | Register address |
| acc_field_i | input | 5 | Source register index or immediate field |
| acc_operand_i | input | 32 | Source operand value |
| acc_rdata_o | output | 32 | Current value of the addressed register |
| acc_illegal_o | output | 1 | Illegal access indication |
| trap_enter_i | input | 1 | Trap-entry strobe |
| trap_pc_i | input | 32 | PC to save on trap entry |
| trap_cause_i | input | 32 | Cause code to save on trap entry |
| trap_return_i | input | 1 | Trap-return strobe |
| irq_pending_i | input | 32 | Raw pending interrupt lines |
| irq_global_en_o | output | 1 | Global interrupt enable |
| irq_enable_o | output | 32 | Per-source interrupt enables |
| trap_vector_o | output | 32 | Trap vector base |
| epc_o | output | 32 | Saved exception PC |
| single_step_o | output | 1 | Single-step enable |

## Verification
A wrong decode or write mask shows up on acc_rdata_o or acc_illegal_o in the same cycle, or at the first read-back one cycle after the write. A lost or reversed enable stack shows on irq_global_en_o one cycle after the strobe, and on the status word at the next read. A counter that skips, stalls or drops a carry shows as a read-back difference that is not exactly the number of cycles between two reads.

// File: rtl/mcsr_pkg.sv
// Shared constants and types for the machine-mode CSR file.
// Assumes a 32-bit datapath and a 12-bit CSR address space.
package mcsr_pkg;
    localparam int XLEN   = 32;
    localparam int ADDR_W = 12;
    localparam int FLD_W  = 5;

    localparam logic [ADDR_W-1:0] ADDR_STATUS  = 12'h300;
    localparam logic [ADDR_W-1:0] ADDR_ISA     = 12'h301;
    localparam logic [ADDR_W-1:0] ADDR_IEN     = 12'h304;
    localparam logic [ADDR_W-1:0] ADDR_TVEC    = 12'h305;
    localparam logic [ADDR_W-1:0] ADDR_VENDOR  = 12'h311;
    localparam logic [ADDR_W-1:0] ADDR_ARCH    = 12'h312;
    localparam logic [ADDR_W-1:0] ADDR_IMPL    = 12'h313;
    localparam logic [ADDR_W-1:0] ADDR_HART    = 12'h314;
    localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 12'h340;
    localparam logic [ADDR_W-1:0] ADDR_EPC     = 12'h341;
    localparam logic [ADDR_W-1:0] ADDR_CAUSE   = 12'h342;
    localparam logic [ADDR_W-1:0] ADDR_IPEND   = 12'h344;
    localparam logic [ADDR_W-1:0] ADDR_STEP    = 12'h7C0;
    localparam logic [ADDR_W-1:0] ADDR_CYC_LO  = 12'hB00;
    localparam logic [ADDR_W-1:0] ADDR_CYC_HI  = 12'hB80;

    // Bit positions inside the status word (software decodes these)
    localparam int ST_IE_BIT  = 3;
    localparam int ST_PIE_BIT = 7;
    localparam int ST_PP_LO   = 11;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_STATUS, SEL_ISA, SEL_IEN, SEL_TVEC, SEL_VENDOR,
        SEL_ARCH, SEL_IMPL, SEL_HART, SEL_SCRATCH, SEL_EPC, SEL_CAUSE,
        SEL_IPEND, SEL_CYC_LO, SEL_CYC_HI, SEL_STEP
    } csr_sel_e;
endpackage

// File: rtl/mcsr_decode.sv
// Address decoder: maps a 12-bit CSR address to a register select.
// It also flags whether the address exists and whether it is read-only.
// Purely combinational; assumes the caller qualifies with a valid strobe.
module mcsr_decode
    import mcsr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output csr_sel_e          sel_o,
    output logic              known_o,
    output logic              ro_o
);
    // Address to select lookup
    always_comb begin
        unique case (addr_i)
            ADDR_STATUS:  sel_o = SEL_STATUS;
            ADDR_ISA:     sel_o = SEL_ISA;
            ADDR_IEN:     sel_o = SEL_IEN;
            ADDR_TVEC:    sel_o = SEL_TVEC;
            ADDR_VENDOR:  sel_o = SEL_VENDOR;
            ADDR_ARCH:    sel_o = SEL_ARCH;
            ADDR_IMPL:    sel_o = SEL_IMPL;
            ADDR_HART:    sel_o = SEL_HART;
            ADDR_SCRATCH: sel_o = SEL_SCRATCH;
            ADDR_EPC:     sel_o = SEL_EPC;
            ADDR_CAUSE:   sel_o = SEL_CAUSE;
            ADDR_IPEND:   sel_o = SEL_IPEND;
            ADDR_STEP:    sel_o = SEL_STEP;
            ADDR_CYC_LO:  sel_o = SEL_CYC_LO;
            ADDR_CYC_HI:  sel_o = SEL_CYC_HI;
            default:      sel_o = SEL_NONE;
        endcase
    end

    // Existence and read-only classification
    always_comb begin
        known_o = (sel_o != SEL_NONE);
        ro_o    = (sel_o == SEL_VENDOR) || (sel_o == SEL_ARCH) ||
                  (sel_o == SEL_IMPL)   || (sel_o == SEL_HART);
    end
endmodule

// File: rtl/mcsr_wmask.sv
// Read-modify-write unit: forms the new register value from the old value,
// the operand and the operation, and says whether a write is requested.
// Set and clear with a zero source field request no write.
module mcsr_wmask
    import mcsr_pkg::*;
#(
    parameter int W = 32,
    parameter int F = 5
) (
    input  csr_op_e        op_i,
    input  logic [F-1:0]   field_i,
    input  logic [W-1:0]   old_i,
    input  logic [W-1:0]   operand_i,
    output logic [W-1:0]   new_o,
    output logic           wr_o
);
    localparam logic [F-1:0] FIELD_ZERO = '0;

    // Combine old value and operand per operation
    always_comb begin
        unique case (op_i)
            OP_WRITE: begin new_o = operand_i;           wr_o = 1'b1; end
            OP_SET:   begin new_o = old_i | operand_i;   wr_o = (field_i != FIELD_ZERO); end
            OP_CLEAR: begin new_o = old_i & ~operand_i;  wr_o = (field_i != FIELD_ZERO); end
            default:  begin new_o = old_i;               wr_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mcsr_cycle.sv
// Free-running cycle counter built from two halves, each loadable on its own.
// A load holds the other half for that cycle; counting resumes on the next edge.
module mcsr_cycle #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo_i,
    input  logic              ld_hi_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt_q;

    // Count, or load the addressed half
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (ld_lo_i) cnt_q[HALF_W-1:0]     <= wdata_i;
        else if (ld_hi_i) cnt_q[CNT_W-1:HALF_W] <= wdata_i;
        else              cnt_q <= cnt_q + CNT_W'(1);
    end

    assign lo_o = cnt_q[HALF_W-1:0];
    assign hi_o = cnt_q[CNT_W-1:HALF_W];
endmodule

// File: rtl/mcsr_file.sv
// Machine-mode CSR file: decode, read mux, write masking, trap stack,
// identification constants and cycle counter. Reads are combinational;
// writes and strobes take effect at the next rising edge. Trap strobes
// take priority over software writes, which are dropped in that cycle.
module mcsr_file
    import mcsr_pkg::*;
#(
    parameter bit          HAS_MUL    = 1'b1,
    parameter int          VER_MAJOR  = 1,
    parameter int          VER_MINOR  = 20,
    parameter logic [31:0] TVEC_RESET = 32'h0000_0000,
    parameter logic [31:0] IEN_MASK   = 32'hFFFF_0888
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic [1:0]        acc_op_i,
    input  logic [11:0]       acc_addr_i,
    input  logic [4:0]        acc_field_i,
    input  logic [31:0]       acc_operand_i,
    output logic [31:0]       acc_rdata_o,
    output logic              acc_illegal_o,
    input  logic              trap_enter_i,
    input  logic [31:0]       trap_pc_i,
    input  logic [31:0]       trap_cause_i,
    input  logic              trap_return_i,
    input  logic [31:0]       irq_pending_i,
    output logic              irq_global_en_o,
    output logic [31:0]       irq_enable_o,
    output logic [31:0]       trap_vector_o,
    output logic [31:0]       epc_o,
    output logic              single_step_o
);
    localparam int          HALF_W   = XLEN / 2;
    localparam logic [XLEN-1:0] ISA_BASE = (XLEN'(1) << 30) | (XLEN'(1) << 8);
    localparam logic [XLEN-1:0] ISA_WORD = HAS_MUL ? (ISA_BASE | (XLEN'(1) << 12)) : ISA_BASE;
    localparam logic [XLEN-1:0] IMPL_WORD = {HALF_W'(VER_MAJOR), HALF_W'(VER_MINOR)};
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    csr_sel_e          sel;
    logic              known, ro;
    logic [XLEN-1:0]   new_val;
    logic              wr_req, wr_en, trap_busy;
    logic              st_ie_q, st_pie_q;
    logic [XLEN-1:0]   tvec_q, scratch_q, epc_q, cause_q, ien_q;
    logic              step_q;
    logic [XLEN-1:0]   cyc_lo, cyc_hi;
    logic [XLEN-1:0]   status_word;

    mcsr_decode u_decode (
        .addr_i  (acc_addr_i),
        .sel_o   (sel),
        .known_o (known),
        .ro_o    (ro)
    );

    // Assemble the status word from its live bits and the fixed privilege field
    always_comb begin
        status_word = '0;
        status_word[ST_PP_LO+1:ST_PP_LO] = 2'b11;
        status_word[ST_IE_BIT]  = st_ie_q;
        status_word[ST_PIE_BIT] = st_pie_q;
    end

    // Read mux: current value of the addressed register
    always_comb begin
        unique case (sel)
            SEL_STATUS:  acc_rdata_o = status_word;
            SEL_ISA:     acc_rdata_o = ISA_WORD;
            SEL_IEN:     acc_rdata_o = ien_q;
            SEL_TVEC:    acc_rdata_o = tvec_q;
            SEL_IMPL:    acc_rdata_o = IMPL_WORD;
            SEL_SCRATCH: acc_rdata_o = scratch_q;
            SEL_EPC:     acc_rdata_o = epc_q;
            SEL_CAUSE:   acc_rdata_o = cause_q;
            SEL_IPEND:   acc_rdata_o = irq_pending_i & IEN_MASK;
            SEL_CYC_LO:  acc_rdata_o = cyc_lo;
            SEL_CYC_HI:  acc_rdata_o = cyc_hi;
            SEL_STEP:    acc_rdata_o = {{(XLEN-1){1'b0}}, step_q};
            default:     acc_rdata_o = '0;
        endcase
    end

    mcsr_wmask #(.W(XLEN), .F(FLD_W)) u_wmask (
        .op_i      (csr_op_e'(acc_op_i)),
        .field_i   (acc_field_i),
        .old_i     (acc_rdata_o),
        .operand_i (acc_operand_i),
        .new_o     (new_val),
        .wr_o      (wr_req)
    );

    // Legality and final write enable
    always_comb begin
        acc_illegal_o = acc_valid_i && (!known || (ro && wr_req));
        trap_busy     = trap_enter_i || trap_return_i;
        wr_en         = acc_valid_i && !acc_illegal_o && wr_req && !trap_busy;
    end

    // Interrupt-enable stack: trap entry pushes, trap return pops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_ie_q  <= 1'b0;
            st_pie_q <= 1'b0;
        end else if (trap_enter_i) begin
            st_pie_q <= st_ie_q;
            st_ie_q  <= 1'b0;
        end else if (trap_return_i) begin
            st_ie_q  <= st_pie_q;
            st_pie_q <= 1'b1;
        end else if (wr_en && sel == SEL_STATUS) begin
            st_ie_q  <= new_val[ST_IE_BIT];
            st_pie_q <= new_val[ST_PIE_BIT];
        end
    end

    // Exception PC: loaded by trap entry or software, word aligned
    always_ff @(posedge clk) begin
        if (!rst_n)                          epc_q <= '0;
        else if (trap_enter_i)               epc_q <= trap_pc_i & ALIGN_MASK;
        else if (wr_en && sel == SEL_EPC)    epc_q <= new_val & ALIGN_MASK;
    end

    // Trap cause: loaded by trap entry or software
    always_ff @(posedge clk) begin
        if (!rst_n)                          cause_q <= '0;
        else if (trap_enter_i)               cause_q <= trap_cause_i;
        else if (wr_en && sel == SEL_CAUSE)  cause_q <= new_val;
    end

    // Trap vector base, word aligned
    always_ff @(posedge clk) begin
        if (!rst_n)                          tvec_q <= TVEC_RESET & ALIGN_MASK;
        else if (wr_en && sel == SEL_TVEC)   tvec_q <= new_val & ALIGN_MASK;
    end

    // Scratch register
    always_ff @(posedge clk) begin
        if (!rst_n)                            scratch_q <= '0;
        else if (wr_en && sel == SEL_SCRATCH)  scratch_q <= new_val;
    end

    // Single-step enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)                          step_q <= 1'b0;
        else if (wr_en && sel == SEL_STEP)   step_q <= new_val[0];
    end

    // Interrupt-enable register: a flop only where the mask has a bit
    for (genvar b = 0; b < XLEN; b++) begin : g_ien
        if (IEN_MASK[b]) begin : g_flop
            // Per-bit enable storage
            always_ff @(posedge clk) begin
                if (!rst_n)                        ien_q[b] <= 1'b0;
                else if (wr_en && sel == SEL_IEN)  ien_q[b] <= new_val[b];
            end
        end else begin : g_tie
            assign ien_q[b] = 1'b0;
        end
    end

    mcsr_cycle #(.HALF_W(XLEN)) u_cycle (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo_i (wr_en && sel == SEL_CYC_LO),
        .ld_hi_i (wr_en && sel == SEL_CYC_HI),
        .wdata_i (new_val),
        .lo_o    (cyc_lo),
        .hi_o    (cyc_hi)
    );

    assign irq_global_en_o = st_ie_q;
    assign irq_enable_o    = ien_q;
    assign trap_vector_o   = tvec_q;
    assign epc_o           = epc_q;
    assign single_step_o   = step_q;
endmodule

// File: rtl/mcsr_file_chk.sv
// Checker for the CSR file: trap stack, legality, constants and counter.
// Attached to every instance of the top module through bind.
module mcsr_file_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid_i,
    input logic [1:0]  acc_op_i,
    input logic [11:0] acc_addr_i,
    input logic [4:0]  acc_field_i,
    input logic [31:0] acc_rdata_o,
    input logic        acc_illegal_o,
    input logic        trap_enter_i,
    input logic [31:0] trap_pc_i,
    input logic        trap_return_i,
    input logic        irq_global_en_o,
    input logic [31:0] epc_o,
    input logic        st_ie_q,
    input logic        st_pie_q,
    input logic [31:0] cyc_lo,
    input logic [31:0] cyc_hi
);
    logic cyc_touched;
    assign cyc_touched = acc_valid_i && !acc_illegal_o && !trap_enter_i && !trap_return_i &&
                         (acc_addr_i == 12'hB00 || acc_addr_i == 12'hB80) &&
                         (acc_op_i == 2'b01 || (acc_op_i[1] && acc_field_i != 5'd0));

    AST_TRAP_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter_i |=> !irq_global_en_o); // R10
    AST_TRAP_PUSHES_IE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter_i |=> st_pie_q == $past(st_ie_q)); // R10
    AST_TRAP_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter_i |=> epc_o == {$past(trap_pc_i[31:2]), 2'b00}); // R10
    AST_RETURN_POPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_return_i && !trap_enter_i) |=> irq_global_en_o == $past(st_pie_q)); // R11
    AST_RO_WRITE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_op_i == 2'b01 && acc_addr_i inside {12'h311, 12'h312, 12'h313, 12'h314})
        |-> acc_illegal_o); // R5
    AST_PP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr_i == 12'h300) |-> acc_rdata_o[12:11] == 2'b11); // R6
    AST_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr_i inside {12'h311, 12'h312, 12'h314}) |-> acc_rdata_o == 32'h0); // R1
    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_touched |=> {cyc_hi, cyc_lo} == $past({cyc_hi, cyc_lo}) + 64'd1); // R9
endmodule

bind mcsr_file mcsr_file_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid_i     (acc_valid_i),
    .acc_op_i        (acc_op_i),
    .acc_addr_i      (acc_addr_i),
    .acc_field_i     (acc_field_i),
    .acc_rdata_o     (acc_rdata_o),
    .acc_illegal_o   (acc_illegal_o),
    .trap_enter_i    (trap_enter_i),
    .trap_pc_i       (trap_pc_i),
    .trap_return_i   (trap_return_i),
    .irq_global_en_o (irq_global_en_o),
    .epc_o           (epc_o),
    .st_ie_q         (st_ie_q),
    .st_pie_q        (st_pie_q),
    .cyc_lo          (cyc_lo),
    .cyc_hi          (cyc_hi)
);

// File: tb/mcsr_file_tb.sv
// Self-checking bench for the CSR file: address sweeps, operation sweeps,
// trap strobes and counter arithmetic, all predicted in the bench.
`timescale 1ns/1ps
module mcsr_file_tb;
    localparam logic [31:0] TVEC_RST = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_op = 2'b00;
    logic [11:0] acc_addr = '0;
    logic [4:0]  acc_field = '0;
    logic [31:0] acc_operand = '0;
    logic [31:0] rdata, rdata_nom;
    logic        illegal, illegal_nom;
    logic        trap_enter = 1'b0, trap_return = 1'b0;
    logic [31:0] trap_pc = '0, trap_cause = '0, irq_pending = '0;
    logic        gen, gen_nom, step, step_nom;
    logic [31:0] ien, ien_nom, tvec, tvec_nom, epc, epc_nom;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rd_nom_cap;

    always #4 clk = ~clk;

    mcsr_file #(.TVEC_RESET(TVEC_RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_op_i(acc_op),
        .acc_addr_i(acc_addr), .acc_field_i(acc_field), .acc_operand_i(acc_operand),
        .acc_rdata_o(rdata), .acc_illegal_o(illegal), .trap_enter_i(trap_enter),
        .trap_pc_i(trap_pc), .trap_cause_i(trap_cause), .trap_return_i(trap_return),
        .irq_pending_i(irq_pending), .irq_global_en_o(gen), .irq_enable_o(ien),
        .trap_vector_o(tvec), .epc_o(epc), .single_step_o(step)
    );

    mcsr_file #(.HAS_MUL(1'b0), .TVEC_RESET(TVEC_RST)) u_dut_nom (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_op_i(acc_op),
        .acc_addr_i(acc_addr), .acc_field_i(acc_field), .acc_operand_i(acc_operand),
        .acc_rdata_o(rdata_nom), .acc_illegal_o(illegal_nom), .trap_enter_i(trap_enter),
        .trap_pc_i(trap_pc), .trap_cause_i(trap_cause), .trap_return_i(trap_return),
        .irq_pending_i(irq_pending), .irq_global_en_o(gen_nom), .irq_enable_o(ien_nom),
        .trap_vector_o(tvec_nom), .epc_o(epc_nom), .single_step_o(step_nom)
    );

    function automatic bit is_known(input logic [11:0] a);
        return a inside {12'h300, 12'h301, 12'h304, 12'h305, 12'h311, 12'h312, 12'h313,
                         12'h314, 12'h340, 12'h341, 12'h342, 12'h344, 12'h7C0,
                         12'hB00, 12'hB80};
    endfunction

    function automatic bit is_ro(input logic [11:0] a);
        return a inside {12'h311, 12'h312, 12'h313, 12'h314};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // One access: drive at the falling edge, sample read data before the rising edge
    task automatic acc(input logic [1:0] op, input logic [11:0] addr, input logic [4:0] fld,
                       input logic [31:0] opnd, output logic [31:0] rd, output logic ill);
        @(negedge clk);
        acc_valid = 1'b1; acc_op = op; acc_addr = addr; acc_field = fld; acc_operand = opnd;
        #1;
        rd = rdata; ill = illegal; rd_nom_cap = rdata_nom;
        @(posedge clk);
        #1 acc_valid = 1'b0;
    endtask

    // Trap strobes, optionally with a simultaneous software write
    task automatic strobe(input logic ent, input logic ret, input logic [31:0] pc,
                          input logic [31:0] cause, input logic with_acc,
                          input logic [11:0] addr, input logic [31:0] opnd);
        @(negedge clk);
        trap_enter = ent; trap_return = ret; trap_pc = pc; trap_cause = cause;
        acc_valid = with_acc; acc_op = 2'b01; acc_addr = addr; acc_field = 5'd1;
        acc_operand = opnd;
        @(posedge clk);
        #1;
        trap_enter = 1'b0; trap_return = 1'b0; acc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        logic [31:0] rd, rd2, model;
        logic        ill;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        acc(2'b00, 12'h300, 0, 0, rd, ill); chk("R12 status", rd, 32'h0000_1800);
        acc(2'b00, 12'h305, 0, 0, rd, ill); chk("R12 tvec", rd, TVEC_RST);
        acc(2'b00, 12'h304, 0, 0, rd, ill); chk("R12 ien", rd, 32'h0);
        acc(2'b00, 12'h340, 0, 0, rd, ill); chk("R12 scratch", rd, 32'h0);
        acc(2'b00, 12'h341, 0, 0, rd, ill); chk("R12 epc", rd, 32'h0);
        acc(2'b00, 12'h342, 0, 0, rd, ill); chk("R12 cause", rd, 32'h0);
        acc(2'b00, 12'hB80, 0, 0, rd, ill); chk("R12 cycle high", rd, 32'h0);
        chk("R12 outputs", {30'h0, gen, step}, 32'h0);

        // R1 identification constants
        acc(2'b00, 12'h311, 0, 0, rd, ill); chk("R1 vendor", rd, 32'h0);
        acc(2'b00, 12'h312, 0, 0, rd, ill); chk("R1 arch", rd, 32'h0);
        acc(2'b00, 12'h314, 0, 0, rd, ill); chk("R1 hart", rd, 32'h0);
        acc(2'b00, 12'h313, 0, 0, rd, ill); chk("R1 impl", rd, (32'd1 << 16) | 32'd20);

        // R2 ISA word with and without multiply
        acc(2'b00, 12'h301, 0, 0, rd, ill);
        chk("R2 isa with mul", rd, (32'd1 << 30) | (32'd1 << 12) | (32'd1 << 8));
        chk("R2 isa without mul", rd_nom_cap, (32'd1 << 30) | (32'd1 << 8));

        // R5 full address sweep: read-only access and write access
        for (int a = 0; a < 4096; a++) begin
            acc(2'b00, 12'(a), 5'd0, 32'h0, rd, ill);
            chk("R5 read legality", {31'h0, ill}, {31'h0, !is_known(12'(a))});
        end
        for (int a = 0; a < 4096; a++) begin
            acc(2'b01, 12'(a), 5'd1, 32'h0, rd, ill);
            chk("R5 write legality", {31'h0, ill}, {31'h0, !is_known(12'(a)) || is_ro(12'(a))});
        end
        acc(2'b10, 12'h313, 5'd3, 32'hFFFF_FFFF, rd, ill);
        chk("R5 set on impl illegal", {31'h0, ill}, 32'h1);
        acc(2'b00, 12'h313, 0, 0, rd, ill); chk("R5 impl unchanged", rd, 32'h0001_0014);

        // R4 zero source field: no write, no illegal
        acc(2'b10, 12'h312, 5'd0, 32'hFFFF_FFFF, rd, ill);
        chk("R4 set x0 on ro legal", {31'h0, ill}, 32'h0);
        acc(2'b01, 12'h340, 5'd1, 32'hFFFF_0000, rd, ill);
        acc(2'b10, 12'h340, 5'd0, 32'h0000_FFFF, rd, ill);
        acc(2'b11, 12'h340, 5'd0, 32'hFFFF_0000, rd, ill);
        acc(2'b00, 12'h340, 0, 0, rd, ill); chk("R4 scratch unchanged", rd, 32'hFFFF_0000);

        // R3 operation sweep on scratch
        model = 32'hFFFF_0000;
        for (int i = 0; i < 48; i++) begin
            logic [31:0] pat;
            logic [1:0]  op;
            pat = 32'h9E37_79B9 * 32'(i + 1);
            op  = 2'(1 + (i % 3));
            acc(op, 12'h340, 5'd7, pat, rd, ill);
            chk("R3 old value returned", rd, model);
            case (op)
                2'b01:   model = pat;
                2'b10:   model = model | pat;
                default: model = model & ~pat;
            endcase
        end
        acc(2'b00, 12'h340, 0, 0, rd, ill); chk("R3 final scratch", rd, model);

        // R6 status bit layout
        acc(2'b01, 12'h300, 5'd1, 32'hFFFF_FFFF, rd, ill);
        acc(2'b00, 12'h300, 0, 0, rd, ill); chk("R6 status all ones", rd, 32'h0000_1888);
        chk("R6 global enable", {31'h0, gen}, 32'h1);
        acc(2'b11, 12'h300, 5'd1, 32'h0000_0008, rd, ill);
        acc(2'b00, 12'h300, 0, 0, rd, ill); chk("R6 status ie cleared", rd, 32'h0000_1880);
        chk("R6 global enable off", {31'h0, gen}, 32'h0);

        // R7 field masks
        acc(2'b01, 12'h305, 5'd1, 32'hFFFF_FFFF, rd, ill);
        acc(2'b00, 12'h305, 0, 0, rd, ill); chk("R7 tvec align", rd, 32'hFFFF_FFFC);
        chk("R7 tvec port", tvec, 32'hFFFF_FFFC);
        acc(2'b01, 12'h341, 5'd1, 32'h1234_5677, rd, ill);
        acc(2'b00, 12'h341, 0, 0, rd, ill); chk("R7 epc align", rd, 32'h1234_5674);
        acc(2'b01, 12'h304, 5'd1, 32'hFFFF_FFFF, rd, ill);
        acc(2'b00, 12'h304, 0, 0, rd, ill); chk("R7 ien mask", rd, 32'hFFFF_0888);
        chk("R7 ien port", ien, 32'hFFFF_0888);
        acc(2'b01, 12'h342, 5'd1, 32'hDEAD_BEEF, rd, ill);
        acc(2'b00, 12'h342, 0, 0, rd, ill); chk("R7 cause full", rd, 32'hDEAD_BEEF);
        acc(2'b01, 12'h7C0, 5'd1, 32'hFFFF_FFFF, rd, ill);
        acc(2'b00, 12'h7C0, 0, 0, rd, ill); chk("R7 step bit", rd, 32'h1);
        chk("R7 step port", {31'h0, step}, 32'h1);
        acc(2'b11, 12'h7C0, 5'd1, 32'h1, rd, ill);
        chk("R7 step port cleared", {31'h0, step}, 32'h0);

        // R8 ignored writes and pending read
        acc(2'b01, 12'h301, 5'd1, 32'h0, rd, ill); chk("R8 isa write legal", {31'h0, ill}, 32'h0);
        acc(2'b00, 12'h301, 0, 0, rd, ill); chk("R8 isa unchanged", rd, 32'h4000_1100);
        irq_pending = 32'hFFFF_FFFF;
        acc(2'b00, 12'h344, 0, 0, rd, ill); chk("R8 pending masked", rd, 32'hFFFF_0888);
        acc(2'b01, 12'h344, 5'd1, 32'h0, rd, ill); chk("R8 pending write legal", {31'h0, ill}, 32'h0);
        acc(2'b00, 12'h344, 0, 0, rd, ill); chk("R8 pending unchanged", rd, 32'hFFFF_0888);
        irq_pending = 32'h0000_0084;
        acc(2'b00, 12'h344, 0, 0, rd, ill); chk("R8 pending bit 7", rd, 32'h0000_0080);

        // R9 counter steps, loads and carry
        acc(2'b00, 12'hB00, 0, 0, rd, ill);
        acc(2'b00, 12'hB00, 0, 0, rd2, ill); chk("R9 one per cycle", rd2 - rd, 32'h1);
        acc(2'b01, 12'hB80, 5'd1, 32'h5, rd, ill);
        acc(2'b01, 12'hB00, 5'd1, 32'hFFFF_FFFF, rd, ill);
        acc(2'b00, 12'hB00, 0, 0, rd, ill); chk("R9 low loaded", rd, 32'hFFFF_FFFF);
        acc(2'b00, 12'hB80, 0, 0, rd, ill); chk("R9 carry into high", rd, 32'h6);
        acc(2'b00, 12'hB00, 0, 0, rd, ill); chk("R9 low wrapped", rd, 32'h1);

        // R10 trap entry with a colliding software write
        acc(2'b01, 12'h340, 5'd1, 32'h55AA_55AA, rd, ill);
        acc(2'b01, 12'h300, 5'd1, 32'h0000_0008, rd, ill);
        strobe(1'b1, 1'b0, 32'h0000_2003, 32'h8000_000B, 1'b1, 12'h340, 32'h0000_1234);
        chk("R10 ie cleared", {31'h0, gen}, 32'h0);
        chk("R10 epc port", epc, 32'h0000_2000);
        acc(2'b00, 12'h300, 0, 0, rd, ill); chk("R10 status after trap", rd, 32'h0000_1880);
        acc(2'b00, 12'h342, 0, 0, rd, ill); chk("R10 cause", rd, 32'h8000_000B);
        acc(2'b00, 12'h340, 0, 0, rd, ill); chk("R10 write dropped", rd, 32'h55AA_55AA);

        // R11 trap return
        strobe(1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 12'h0, 32'h0);
        chk("R11 ie restored", {31'h0, gen}, 32'h1);
        acc(2'b00, 12'h300, 0, 0, rd, ill); chk("R11 status after return", rd, 32'h0000_1888);

        // R10 entry wins over simultaneous return
        strobe(1'b1, 1'b1, 32'h0000_4000, 32'h0000_0002, 1'b0, 12'h0, 32'h0);
        acc(2'b00, 12'h300, 0, 0, rd, ill); chk("R10 entry priority", rd, 32'h0000_1880);
        acc(2'b00, 12'h341, 0, 0, rd, ill); chk("R10 epc priority", rd, 32'h0000_4000);

        summary();
    end
endmodule